// File: doc/BRIEF.md
# Bit-Test, Modify and Skip Unit

This unit executes the whole family of bit-test instructions on a 36-bit accumulator word. One operation picks a mask source (an 18-bit immediate or a full 36-bit operand), may swap the mask's two halves, and tests the accumulator under that mask. It can also clear, complement or set the masked bits, and it decides whether the next instruction is skipped. The operand arrives already fetched and resolved. Address generation, memory traffic and instruction prefetch belong to neighbouring blocks.

A 6-bit operation code covers all 64 combinations. Each accepted operation returns, one clock later, the new accumulator value, a write strobe for it and the skip decision, all framed by a single valid pulse. The skip rule uses one sense bit. That bit is XORed with a "masked bits nonzero" flag, and the flag is forced low for forms that do not test. The test always looks at the accumulator as it was before modification.

Operation code layout (bit 5 down to bit 0): `op_in[5:4]` modification, `op_in[3]` skip sense, `op_in[2]` test enable, `op_in[1]` half swap, `op_in[0]` operand source (1 = full operand, 0 = immediate).

Top module: `bit_test_skip_unit`

## Requirements
- R1: With modification code 00 the result equals the incoming accumulator and `acc_we` stays low in the valid cycle.
- R2: Modification code 01 gives the accumulator AND NOT mask, with `acc_we` high.
- R3: Modification code 10 gives the accumulator XOR mask, with `acc_we` high.
- R4: Modification code 11 gives the accumulator OR mask, with `acc_we` high.
- R5: Skip code {sense,test} = 00 never skips.
- R6: Skip code 01 skips exactly when the accumulator AND mask is nonzero.
- R7: Skip code 10 always skips.
- R8: Skip code 11 skips exactly when the accumulator AND mask is zero.
- R9: With `op_in[1]` = 1 the mask's upper and lower 18-bit halves are exchanged before both the test and the modification.
- R10: With `op_in[0]` = 0 the mask is {18 zero bits, `opnd_in[17:0]`}, and the upper 18 operand bits have no effect. With `op_in[0]` = 1 the whole operand is the mask.
- R11: The skip decision is taken on the accumulator value from before the modification.
- R12: An operation accepted on a clock edge (`in_valid` and `in_ready`) shows its results after that edge with `out_valid` high for exactly one cycle. After reset all outputs are zero and `in_ready` rises one cycle after reset is released.
- R13: `acc_we` and `skip_out` are never high when `out_valid` is low, and `acc_out` holds its last value between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| op_in | input | 6 | Operation code (modification, sense, test, swap, source) |
| acc_in | input | 36 | Accumulator value before the operation |
| opnd_in | input | 36 | Resolved operand or immediate in the low half |
| out_valid | output | 1 | One-cycle result pulse |
| acc_out | output | 36 | Accumulator value after the operation |
| acc_we | output | 1 | Write the accumulator with `acc_out` |
| skip_out | output | 1 | Skip the next instruction |

## Verification
Modification and test share one cycle and one mask, so a combined form such as clear-and-skip-if-nonzero can give a skip that would be wrong if it were judged on the written result. The bench provokes this by aiming a clearing or setting mask at bits that are respectively set or clear. It then expects the skip to match the original accumulator while `acc_out` shows the modified word. Swapped immediate masks are run through the same combined forms, so that the half exchange is shown to reach both the test and the modification.

// File: rtl/tsk_pkg.sv
package tsk_pkg;
    typedef enum logic [1:0] {
        MOD_KEEP = 2'b00,
        MOD_ZERO = 2'b01,
        MOD_COMP = 2'b10,
        MOD_ONES = 2'b11
    } mod_e;

    typedef struct packed {
        mod_e mod;      // [5:4]
        logic sense;    // [3] XORed with the nonzero flag
        logic test;     // [2] enables the nonzero flag
        logic swap;     // [1] exchange mask halves
        logic full;     // [0] full operand vs immediate
    } op_t;
endpackage

// File: rtl/tsk_mask_gen.sv
module tsk_mask_gen #(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] opnd,
    input  logic              full,
    input  logic              swap,
    output logic [WORD_W-1:0] mask
);
    logic [WORD_W-1:0] raw;

    always_comb begin
        if (full) raw = opnd;
        else      raw = {{HALF_W{1'b0}}, opnd[HALF_W-1:0]};
    end

    for (genvar i = 0; i < HALF_W; i++) begin : g_half
        assign mask[i]          = swap ? raw[i+HALF_W] : raw[i];
        assign mask[i+HALF_W]   = swap ? raw[i]        : raw[i+HALF_W];
    end
endmodule

// File: rtl/tsk_modify.sv
module tsk_modify
    import tsk_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mask,
    input  mod_e              mode,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        unique case (mode)
            MOD_ZERO: result = acc & ~mask;
            MOD_COMP: result = acc ^ mask;
            MOD_ONES: result = acc | mask;
            default:  result = acc;
        endcase
    end
endmodule

// File: rtl/tsk_skip_eval.sv
module tsk_skip_eval #(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mask,
    input  logic              sense,
    input  logic              test,
    output logic              skip
);
    logic hit;

    always_comb begin
        hit  = |(acc & mask);
        skip = sense ^ (test & hit);
    end
endmodule

// File: rtl/bit_test_skip_unit.sv
module bit_test_skip_unit
    import tsk_pkg::*;
#(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W,
    localparam int OP_W = $bits(op_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   op_in,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] opnd_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] acc_out,
    output logic              acc_we,
    output logic              skip_out
);
    typedef struct packed {
        logic              ready;
        logic              valid;
        logic              we;
        logic              skip;
        logic [WORD_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;
    op_t    op;
    logic [WORD_W-1:0] mask, new_acc;
    logic   skip_c;
    logic   fire;

    assign op = op_t'(op_in);

    tsk_mask_gen #(.HALF_W(HALF_W)) u_mask (
        .opnd (opnd_in),
        .full (op.full),
        .swap (op.swap),
        .mask (mask)
    );

    tsk_modify #(.WORD_W(WORD_W)) u_mod (
        .acc    (acc_in),
        .mask   (mask),
        .mode   (op.mod),
        .result (new_acc)
    );

    tsk_skip_eval #(.WORD_W(WORD_W)) u_skip (
        .acc   (acc_in),
        .mask  (mask),
        .sense (op.sense),
        .test  (op.test),
        .skip  (skip_c)
    );

    always_comb begin
        fire        = in_valid & st_q.ready;
        st_d        = st_q;
        st_d.ready  = 1'b1;
        st_d.valid  = fire;
        st_d.we     = fire & (op.mod != MOD_KEEP);
        st_d.skip   = fire & skip_c;
        if (fire) st_d.acc = new_acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = st_q.ready;
    assign out_valid = st_q.valid;
    assign acc_we    = st_q.we;
    assign skip_out  = st_q.skip;
    assign acc_out   = st_q.acc;
endmodule

// File: rtl/tsk_checker.sv
module tsk_checker #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [5:0]        op_in,
    input logic [WORD_W-1:0] acc_in,
    input logic              out_valid,
    input logic [WORD_W-1:0] acc_out,
    input logic              acc_we,
    input logic              skip_out
);
    assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && in_ready));

    assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in[5:4] == 2'b00)) |-> (!acc_we && acc_out == $past(acc_in)));

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in[5:4] != 2'b00)) |-> acc_we);

    assert_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in[3:2] == 2'b00)) |-> !skip_out);

    assert_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_in[3:2] == 2'b10)) |-> skip_out);

    assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!acc_we && !skip_out && $stable(acc_out)));
endmodule

bind bit_test_skip_unit tsk_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op_in     (op_in),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .acc_out   (acc_out),
    .acc_we    (acc_we),
    .skip_out  (skip_out)
);

// File: tb/tb_bit_test_skip_unit.sv
`timescale 1ns/100ps
module tb_bit_test_skip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  op_in = '0;
    logic [35:0] acc_in = '0;
    logic [35:0] opnd_in = '0;
    logic        out_valid;
    logic [35:0] acc_out;
    logic        acc_we;
    logic        skip_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bit_test_skip_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_in(op_in), .acc_in(acc_in), .opnd_in(opnd_in),
        .out_valid(out_valid), .acc_out(acc_out), .acc_we(acc_we), .skip_out(skip_out)
    );

    // op = {mod[1:0], sense, test, swap, full}
    function automatic logic [5:0] mkop(input logic [1:0] m, input logic [1:0] sk,
                                        input logic sw, input logic fl);
        return {m, sk, sw, fl};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one operation and check the result after the accepting edge
    task automatic run_op(input string tag, input logic [5:0] op, input logic [35:0] acc,
                          input logic [35:0] opnd, input logic [35:0] exp_acc,
                          input logic exp_we, input logic exp_skip);
        @(negedge clk);
        op_in = op; acc_in = acc; opnd_in = opnd; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " acc"},   64'(acc_out),   64'(exp_acc));
        chk({tag, " we"},    64'(acc_we),    64'(exp_we));
        chk({tag, " skip"},  64'(skip_out),  64'(exp_skip));
    endtask

    task automatic t_reset;
        chk("R12 reset valid", 64'(out_valid), 64'd0);
        chk("R12 reset acc",   64'(acc_out),   64'd0);
        chk("R12 reset we",    64'(acc_we),    64'd0);
        chk("R12 reset skip",  64'(skip_out),  64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R12 ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic t_modes;
        // full operand mask, never skip
        run_op("R1 keep", mkop(2'b00, 2'b00, 0, 1), 36'h123456789, 36'h0F0F0F0F0, 36'h123456789, 0, 0);
        run_op("R2 zero", mkop(2'b01, 2'b00, 0, 1), 36'h123456789, 36'h0F0F0F0F0, 36'h103050709, 1, 0);
        run_op("R3 comp", mkop(2'b10, 2'b00, 0, 1), 36'h123456789, 36'h0F0F0F0F0, 36'h1D3B59779, 1, 0);
        run_op("R4 ones", mkop(2'b11, 2'b00, 0, 1), 36'h123456789, 36'h0F0F0F0F0, 36'h1F3F5F7F9, 1, 0);
    endtask

    task automatic t_skips;
        run_op("R5 never hit",   mkop(2'b00, 2'b00, 0, 1), 36'h000000100, 36'h000000100, 36'h000000100, 0, 0);
        run_op("R6 N hit",       mkop(2'b00, 2'b01, 0, 1), 36'h000000100, 36'h000000180, 36'h000000100, 0, 1);
        run_op("R6 N miss",      mkop(2'b00, 2'b01, 0, 1), 36'h000000100, 36'h000000080, 36'h000000100, 0, 0);
        run_op("R7 A miss",      mkop(2'b00, 2'b10, 0, 1), 36'h000000000, 36'hFFFFFFFFF, 36'h000000000, 0, 1);
        run_op("R8 E miss",      mkop(2'b00, 2'b11, 0, 1), 36'h800000000, 36'h7FFFFFFFF, 36'h800000000, 0, 1);
        run_op("R8 E hit",       mkop(2'b00, 2'b11, 0, 1), 36'h800000000, 36'h800000000, 36'h800000000, 0, 0);
    endtask

    task automatic t_swap;
        // mask bit0 swapped to bit18
        run_op("R9 swap test", mkop(2'b00, 2'b01, 1, 1), 36'h000040000, 36'h000000001, 36'h000040000, 0, 1);
        run_op("R9 swap ones", mkop(2'b11, 2'b00, 1, 1), 36'h000000000, 36'h000000001, 36'h000040000, 1, 0);
        run_op("R9 swap both", mkop(2'b10, 2'b00, 1, 1), 36'h000000000, 36'h800000001, 36'h000060000, 1, 0);
    endtask

    task automatic t_immediate;
        run_op("R10 imm upper ignored", mkop(2'b11, 2'b00, 0, 0), 36'h000000000, 36'hFFFFC0003, 36'h000000003, 1, 0);
        run_op("R10 imm no hit upper",  mkop(2'b00, 2'b01, 0, 0), 36'hFFFFC0000, 36'hFFFFC0000, 36'hFFFFC0000, 0, 0);
        run_op("R10 imm swapped",       mkop(2'b01, 2'b11, 1, 0), 36'hFFFFFFFFF, 36'hFFFFC0003, 36'hFFFF3FFFF, 1, 0);
    endtask

    task automatic t_premod;
        run_op("R11 zero then N",  mkop(2'b01, 2'b01, 0, 1), 36'h00000000F, 36'h00000000F, 36'h000000000, 1, 1);
        run_op("R11 ones then E",  mkop(2'b11, 2'b11, 0, 1), 36'h000000000, 36'h00000000F, 36'h00000000F, 1, 1);
        run_op("R11 comp imm swap N", mkop(2'b10, 2'b01, 1, 0), 36'h000000000, 36'h000000001, 36'h000040000, 1, 0);
    endtask

    task automatic t_pulse;
        run_op("R12 pulse op", mkop(2'b11, 2'b10, 0, 1), 36'h000000000, 36'h0000000AA, 36'h0000000AA, 1, 1);
        @(negedge clk);
        chk("R12 pulse ends", 64'(out_valid), 64'd0);
        chk("R13 we idle",    64'(acc_we),    64'd0);
        chk("R13 skip idle",  64'(skip_out),  64'd0);
        chk("R13 acc held",   64'(acc_out),   64'h0000000AA);
        // back-to-back operations
        @(negedge clk);
        op_in = mkop(2'b01, 2'b00, 0, 1); acc_in = 36'h0000000FF; opnd_in = 36'h00000000F; in_valid = 1'b1;
        @(negedge clk);
        chk("R12 b2b first", 64'(acc_out), 64'h0000000F0);
        op_in = mkop(2'b00, 2'b10, 0, 1); acc_in = 36'h000000123;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 b2b second valid", 64'(out_valid), 64'd1);
        chk("R1 b2b second acc",    64'(acc_out),   64'h000000123);
        chk("R1 b2b second we",     64'(acc_we),    64'd0);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_skips();
        t_swap();
        t_immediate();
        t_premod();
        t_pulse();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule